// File: doc/BRIEF.md
# GPIO Port Register Block

This block is the bus-facing register file for one general-purpose I/O port of up to eight pins. Software reaches it through a plain synchronous interface: an address, a write strobe, write data, and a read-data output that follows the address in the same cycle. On the pin side, the block produces an output value and an output-enable for each pin. It takes in the raw pad level for each pin. It also exchanges output, output-enable and input signals with a peripheral that can take over any pin.

Four per-port registers decide what each pin does: the output latch, the direction, the peripheral-takeover select and the digital enable. A system clock-gate register sits at the bottom of the same address map and holds one enable bit per port. This instance answers to one of those bits. Until that bit is set and a short settling time has passed, the port registers cannot be reached. A busy output tells the bus side when this is the case.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset every register is 0, every pin_oe and pin_out bit is 0, alt_in is 0, and port_busy is 1.
- R2: The clock-gate register at offset 0x000 stores the low NPORTS bits of a write, is always accessible, and reads back zero-extended. Only bit PORT_ID enables this port.
- R3: port_busy is 1 whenever this port's gate bit is 0. Once the bit is set, port_busy stays 1 for the two cycles after the setting write, and falls to 0 after that. While port_busy is 1, any port register read returns 0 and any port register write is ignored.
- R4: The port registers decode at these offsets: output latch 0x3FC, direction 0x400, peripheral select 0x420, digital enable 0x51C. Any other address except 0x000 reads 0 and ignores writes.
- R5: A pin with enable=1 and select=0 drives pin_out from its latch bit. It drives pin_oe from its direction bit, where 1 means output.
- R6: A pin with enable=1 and select=1 drives pin_out from alt_out and pin_oe from alt_oe. It presents its synchronized input on alt_in.
- R7: A pin with enable=0 has pin_out=0, pin_oe=0 and alt_in=0, and its bit of the data register reads 0.
- R8: For an enabled pin, a read of the data register returns the latch bit when the direction bit is 1. When the direction bit is 0, it returns the pad level after a two-flop synchronizer, which lags pin_in by two clock edges.
- R9: Bits at and above W in every port register read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| port_busy | output | 1 | Port registers not reachable this cycle |
| pin_in | input | W | Raw pad levels |
| pin_out | output | W | Pad output values |
| pin_oe | output | W | Pad output enables |
| alt_out | input | W | Peripheral output values |
| alt_oe | input | W | Peripheral output enables |
| alt_in | output | W | Synchronized pad levels for the peripheral |

## Verification
A wrong enable or select bit shows up on pin_oe and pin_out in the cycle after the write that set it. A stale or wrong latch bit shows up only when the data register is read back with the pin set as output. A settle counter off by one moves the first cycle in which a write takes effect. The bench pins this down by attempting a write in every busy cycle and reading back afterwards. A synchronizer with the wrong depth shows up as a read one edge early or late, so the bench samples the data register after each edge that follows a pad change.

// File: rtl/gpio_port_pkg.sv
// Shared constants and the address decoder for the GPIO port block.
// Assumes a 12-bit byte offset and an 8-bit register data path.
package gpio_port_pkg;
    localparam int ADDR_W = 12;
    localparam int BUS_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_GATE  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h3FC;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_AFSEL = 12'h420;
    localparam logic [ADDR_W-1:0] OFS_DEN   = 12'h51C;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_GATE, SEL_DATA, SEL_DIR, SEL_AFSEL, SEL_DEN
    } reg_sel_e;

    // Map a byte offset onto the register it names.
    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_GATE:  return SEL_GATE;
            OFS_DATA:  return SEL_DATA;
            OFS_DIR:   return SEL_DIR;
            OFS_AFSEL: return SEL_AFSEL;
            OFS_DEN:   return SEL_DEN;
            default:   return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/gpio_clk_gate.sv
// Clock-gate register with one bit per port, plus the settle counter
// for the port selected by PORT_ID. Assumes the register is always
// writable. Ready rises SETTLE cycles after the write that set the bit.
module gpio_clk_gate #(
    parameter int NPORTS  = 6,
    parameter int PORT_ID = 0,
    parameter int SETTLE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_gate,
    input  logic [NPORTS-1:0] wdata,
    output logic [NPORTS-1:0] gate_q,
    output logic              ready
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(SETTLE);

    logic [CNT_W-1:0] settle_cnt;

    // Hold the per-port enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       gate_q <= '0;
        else if (wr_gate) gate_q <= wdata;
    end

    // Count settle cycles while this port's bit is set; restart when cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate_q[PORT_ID]) settle_cnt <= '0;
        else if (settle_cnt != CNT_DONE) settle_cnt <= settle_cnt + 1'b1;
    end

    // Port is reachable once enabled and settled.
    always_comb ready = gate_q[PORT_ID] && (settle_cnt == CNT_DONE);
endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the pad inputs. Assumes each pin is
// independent, so no bus coherency is needed across bits.
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_raw,
    output logic [W-1:0] pad_sync
);
    logic [W-1:0] stage1;

    // Move the pad level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            pad_sync <= '0;
        end else begin
            stage1   <= pad_raw;
            pad_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
// The four per-port registers, each W bits wide. Assumes the write
// strobe is already qualified with port readiness by the caller.
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] afsel_q,
    output logic [W-1:0] den_q
);
    // Store a write in the addressed register; all clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            dir_q   <= '0;
            afsel_q <= '0;
            den_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA:  data_q  <= wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_AFSEL: afsel_q <= wdata;
                SEL_DEN:   den_q   <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-pin steering between the GPIO latch and the peripheral, gated by
// the digital enable. Also forms the data-register read value.
module gpio_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] afsel_q,
    input  logic [W-1:0] den_q,
    input  logic [W-1:0] pad_sync,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] alt_in,
    output logic [W-1:0] rd_data
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // Steer one pin from its owner, or quiet it when disabled.
        always_comb begin
            pin_out[i] = den_q[i] && (afsel_q[i] ? alt_out[i] : data_q[i]);
            pin_oe[i]  = den_q[i] && (afsel_q[i] ? alt_oe[i]  : dir_q[i]);
            alt_in[i]  = den_q[i] && afsel_q[i] && pad_sync[i];
            rd_data[i] = den_q[i] && (dir_q[i] ? data_q[i] : pad_sync[i]);
        end
    end
endmodule

// File: rtl/gpio_port_ctl.sv
// Top of the GPIO port block: address decode, gated access and read mux.
// Assumes W <= 8 and NPORTS <= 8; the read path is combinational.
module gpio_port_ctl
    import gpio_port_pkg::*;
#(
    parameter int W       = 8,
    parameter int NPORTS  = 6,
    parameter int PORT_ID = 0,
    parameter int SETTLE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              port_busy,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    input  logic [W-1:0]      alt_out,
    input  logic [W-1:0]      alt_oe,
    output logic [W-1:0]      alt_in
);
    reg_sel_e          sel;
    logic              ready;
    logic [NPORTS-1:0] gate_q;
    logic [W-1:0]      data_q, dir_q, afsel_q, den_q;
    logic [W-1:0]      pad_sync, rd_data;

    // Decode the offset once for write and read paths.
    always_comb sel = decode_ofs(bus_addr);

    gpio_clk_gate #(.NPORTS(NPORTS), .PORT_ID(PORT_ID), .SETTLE(SETTLE)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .wr_gate(bus_we && (sel == SEL_GATE)),
        .wdata(bus_wdata[NPORTS-1:0]),
        .gate_q(gate_q), .ready(ready)
    );

    gpio_cfg_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_we && ready), .sel(sel),
        .wdata(bus_wdata[W-1:0]),
        .data_q(data_q), .dir_q(dir_q), .afsel_q(afsel_q), .den_q(den_q)
    );

    gpio_in_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_raw(pin_in), .pad_sync(pad_sync)
    );

    gpio_pin_mux #(.W(W)) u_mux (
        .data_q(data_q), .dir_q(dir_q), .afsel_q(afsel_q), .den_q(den_q),
        .pad_sync(pad_sync), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_in(alt_in), .rd_data(rd_data)
    );

    // Busy whenever the port registers are not reachable.
    always_comb port_busy = !ready;

    // Select read data; port registers read 0 while busy.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_GATE:  bus_rdata = BUS_W'(gate_q);
            SEL_DATA:  if (ready) bus_rdata = BUS_W'(rd_data);
            SEL_DIR:   if (ready) bus_rdata = BUS_W'(dir_q);
            SEL_AFSEL: if (ready) bus_rdata = BUS_W'(afsel_q);
            SEL_DEN:   if (ready) bus_rdata = BUS_W'(den_q);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_ctl_chk.sv
// Property checker for gpio_port_ctl, attached with bind below.
module gpio_port_ctl_chk
    import gpio_port_pkg::*;
#(
    parameter int W       = 8,
    parameter int NPORTS  = 6,
    parameter int PORT_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              port_busy,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      data_q,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      den_q,
    input logic [NPORTS-1:0] gate_q
);
    // R7
    den_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | pin_out) & ~den_q) == '0);

    // R3
    gate_off_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q[PORT_ID] |-> port_busy);

    // R3
    settle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q[PORT_ID]) |-> port_busy);

    // R3
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_busy && bus_we && bus_addr == OFS_DIR) |=> $stable(dir_q));

    // R9
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFS_GATE) |-> ((bus_rdata >> W) == '0));

    // R8
    out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_busy && bus_addr == OFS_DATA) |->
            (((bus_rdata[W-1:0] ^ data_q) & den_q & dir_q) == '0));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.W(W), .NPORTS(NPORTS), .PORT_ID(PORT_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .port_busy(port_busy), .pin_out(pin_out),
    .pin_oe(pin_oe), .data_q(data_q), .dir_q(dir_q), .den_q(den_q),
    .gate_q(gate_q)
);

// File: tb/gpio_port_ctl_test.sv
// Bench for gpio_port_ctl with a 5-pin port answering to gate bit 5.
module gpio_port_ctl_test;
    localparam int W = 5, NP = 6, PID = 5;
    localparam logic [11:0] A_GATE = 12'h000, A_DATA = 12'h3FC, A_DIR = 12'h400,
                            A_SEL = 12'h420, A_DEN = 12'h51C;

    logic clk = 0, rst_n = 0;
    logic [11:0] bus_addr = '0;
    logic bus_we = 0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic port_busy;
    logic [W-1:0] pin_in = '0, pin_out, pin_oe, alt_out = '0, alt_oe = '0, alt_in;
    int checks = 0, errors = 0;

    gpio_port_ctl #(.W(W), .NPORTS(NP), .PORT_ID(PID)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_busy(port_busy),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Write one register; returns 1 ns after the capturing edge.
    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(posedge clk); #1;
        bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1", "busy", {7'd0, port_busy}, 8'd1);
        chk("R1", "pin_oe", {3'd0, pin_oe}, 8'd0);
        chk("R1", "pin_out", {3'd0, pin_out}, 8'd0);
        chk("R1", "alt_in", {3'd0, alt_in}, 8'd0);
        rd(A_GATE, v); chk("R1", "gate", v, 8'd0);
        // R3 writes while gated are lost
        wr(A_DIR, 8'h1F);
        // R2 another port's bit does not open this one; readback is masked
        wr(A_GATE, 8'hDF); step(4);
        chk("R2", "busy other bit", {7'd0, port_busy}, 8'd1);
        rd(A_GATE, v); chk("R2", "gate readback", v, 8'h1F);
        // R3 settle: two busy cycles after the setting write, writes ignored
        wr(A_GATE, 8'h20);
        chk("R3", "busy cycle 1", {7'd0, port_busy}, 8'd1);
        rd(A_DIR, v); chk("R3", "read while busy", v, 8'd0);
        wr(A_DIR, 8'h1F);
        chk("R3", "busy cycle 2", {7'd0, port_busy}, 8'd1);
        wr(A_DIR, 8'h1F);
        chk("R3", "ready", {7'd0, port_busy}, 8'd0);
        rd(A_DIR, v); chk("R3", "busy writes lost", v, 8'd0);
        rd(A_GATE, v); chk("R2", "gate readback", v, 8'h20);
        // R9 upper bits
        wr(A_DIR, 8'hFF); rd(A_DIR, v); chk("R9", "dir width", v, 8'h1F);
        wr(A_DEN, 8'hE0); rd(A_DEN, v); chk("R9", "den upper", v, 8'h00);
        // R4 unmapped offset
        wr(12'h404, 8'hFF); rd(12'h404, v); chk("R4", "unmapped read", v, 8'd0);
        rd(A_DIR, v); chk("R4", "dir untouched", v, 8'h1F);
        wr(A_SEL, 8'h0A); rd(A_SEL, v); chk("R4", "select offset", v, 8'h0A);
        // R8 synchronizer lag on an input pin
        wr(A_SEL, 8'h00); wr(A_DIR, 8'h00); wr(A_DEN, 8'h1F);
        pin_in = 5'h00; step(3);
        pin_in = 5'h16; step(1);
        rd(A_DATA, v); chk("R8", "after one edge", v, 8'h00);
        step(1);
        rd(A_DATA, v); chk("R8", "after two edges", v, 8'h16);
        // R5 R6 R7 R8 sweep over every enable and select pattern
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                logic [W-1:0] den, sl, dr, dt, ao, ae, pi;
                logic [W-1:0] e_out, e_oe, e_ain, e_rd;
                den = W'(a); sl = W'(b); dr = W'(a * 3 + b); dt = W'(b * 5 + a);
                ao = ~W'(a); ae = W'(b) ^ 5'h05; pi = W'(a) ^ W'(b << 1);
                wr(A_DEN, {3'd0, den}); wr(A_SEL, {3'd0, sl});
                wr(A_DIR, {3'd0, dr}); wr(A_DATA, {3'd0, dt});
                alt_out = ao; alt_oe = ae; pin_in = pi;
                step(3);
                e_out = den & ((sl & ao) | (~sl & dt));
                e_oe  = den & ((sl & ae) | (~sl & dr));
                e_ain = den & sl & pi;
                e_rd  = den & ((dr & dt) | (~dr & pi));
                chk("R5 R6 R7", "pin_out", {3'd0, pin_out}, {3'd0, e_out});
                chk("R5 R6 R7", "pin_oe", {3'd0, pin_oe}, {3'd0, e_oe});
                chk("R6 R7", "alt_in", {3'd0, alt_in}, {3'd0, e_ain});
                rd(A_DATA, v); chk("R7 R8", "data read", v, {3'd0, e_rd});
            end
        end
        // R3 clearing the gate closes the port at once
        wr(A_GATE, 8'h00);
        chk("R3", "busy after clear", {7'd0, port_busy}, 8'd1);
        rd(A_DEN, v); chk("R3", "read after clear", v, 8'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule